// File: doc/BRIEF.md
# Link Change Interrupt Status Logic

This block watches the link-up signals of a group of PHYs and turns link changes on two monitored channels into interrupt events. Each channel has a select input that picks one PHY out of the link status vector. When the link level of the picked PHY moves in either direction, the channel's event bit is set and stays set until software clears it. The event bits can be read in two ways. The raw view shows every pending event. The masked view shows only those events whose per-channel enable bit is set. A single registered interrupt line is the OR of the masked bits.

Software reaches the block through a simple word-addressed register port with single-cycle reads. Writing ones to either status view clears the matching events. When the test input is high, the same writes set events instead, so interrupt handling can be exercised without touching the links. The enable bits sit in a third register.

Top module: `link_evt_irq`

## Requirements
- R1: Status and enable words carry data only in bits 1:0. Bits 31:2 always read as zero, and writing to them has no effect.
- R2: Event bit 0 follows the PHY picked by select 0 (bits 4:0 of `phy_sel` by default). Event bit 1 follows the PHY picked by select 1 (the next `SEL_W` bits).
- R3: A rising or a falling edge on the picked PHY's link bit, compared with the sample from the previous cycle, sets the channel's event bit at the same clock edge that samples the new level.
- R4: With `test_en` low, writing to the raw status word (offset 0) clears each event bit written as 1 and leaves each bit written as 0 unchanged.
- R5: With `test_en` high, writing a 1 to the raw or masked status word sets that event bit instead of clearing it. Bits written as 0 stay unchanged.
- R6: The masked status word (offset 1) reads each bit as 1 only when both its event bit and its enable bit are 1.
- R7: With `test_en` low, writing 1 to a bit of the masked status word clears the underlying event bit, whatever the state of its enable bit.
- R8: Reset clears the event bits, the enable bits, `irq_o` and `reg_rdata`.
- R9: If a link change and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R10: `irq_o` equals the OR of the masked bits as they stood one clock earlier.
- R11: The enable word (offset 2) is readable and writable in bits 1:0. A read whose `reg_rd` is sampled at one edge presents its data on `reg_rdata` right after that edge, and the value holds until the next read. Offsets other than 0, 1 and 2 read as zero.
- R12: The first link sample after reset does not raise an event, whatever the link levels are at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_stat | input | NPHY | Link-up level of every PHY |
| phy_sel | input | NCH*SEL_W | Packed PHY selects, channel 0 in the low bits |
| test_en | input | 1 | When high, status writes set events instead of clearing them |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
On every cycle the assertions check several invariants. A detected change always leaves its event bit set, and this holds under a colliding clear as well. An event bit changes only through a change, a clear or a test-mode set. The reserved read bits stay zero, and the enable bits move only on writes to their offset. `irq_o` follows the masked bits with one cycle of lag, and no change is detected on the first sample after reset. The bench scenarios cover what the assertions cannot. These are the mapping from every pair of select values to the right event bit, and the arithmetic results of every combination of prior events, write data, offset and test mode. They also cover the read values at unmapped offsets and the quiet first cycle with links already up during reset.

// File: rtl/lce_pkg.sv
package lce_pkg;

  // word offsets of the register port
  localparam int unsigned OFS_RAW = 0;
  localparam int unsigned OFS_MSK = 1;
  localparam int unsigned OFS_EN  = 2;

  function automatic int unsigned sel_width(input int unsigned nphy);
    return (nphy < 2) ? 1 : $clog2(nphy);
  endfunction

endpackage

// File: rtl/lce_change_det.sv
module lce_change_det #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned NPHY  = 32,
  parameter int unsigned SEL_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPHY-1:0]       link_stat,
  input  logic [NCH*SEL_W-1:0]  phy_sel,
  output logic [NCH-1:0]        chg
);

  logic [NCH-1:0] cur_lvl;
  logic [NCH-1:0] prev_lvl;
  logic           prev_vld;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SEL_W-1:0] sel_c;
    assign sel_c = phy_sel[c*SEL_W +: SEL_W];

    always_comb begin
      cur_lvl[c] = 1'b0;
      for (int p = 0; p < NPHY; p++) begin
        if (sel_c == SEL_W'(p)) cur_lvl[c] = link_stat[p];
      end
    end

    assign chg[c] = prev_vld && (cur_lvl[c] != prev_lvl[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= '0;
      prev_vld <= 1'b0;
    end else begin
      prev_lvl <= cur_lvl;
      prev_vld <= 1'b1;
    end
  end

  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !prev_vld |-> (chg == '0)); // R12

endmodule

// File: rtl/lce_event_reg.sv
module lce_event_reg #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hw_chg,
  input  logic           wr_evt,
  input  logic [NCH-1:0] wbits,
  input  logic           test_en,
  output logic [NCH-1:0] ev
);

  logic [NCH-1:0] clr_req;
  logic [NCH-1:0] set_req;
  logic [NCH-1:0] ev_nxt;

  assign clr_req = (wr_evt && !test_en) ? wbits : '0;
  assign set_req = (wr_evt &&  test_en) ? wbits : '0;

  always_comb begin
    ev_nxt = ev & ~clr_req;
    ev_nxt = ev_nxt | set_req;
    ev_nxt = ev_nxt | hw_chg;   // hardware set has last word
  end

  always_ff @(posedge clk) begin
    if (rst) ev <= '0;
    else     ev <= ev_nxt;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_HW_SET: assert property (@(posedge clk) disable iff (rst)
      hw_chg[i] |=> ev[i]); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (hw_chg[i] && wr_evt && wbits[i] && !test_en) |=> ev[i]); // R9
    AST_EV_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ev[i] && !(wr_evt && wbits[i] && !test_en)) |=> ev[i]); // R4
    AST_EV_NO_SPUR: assert property (@(posedge clk) disable iff (rst)
      (!ev[i] && !hw_chg[i] && !(wr_evt && wbits[i] && test_en)) |=> !ev[i]); // R5
  end

endmodule

// File: rtl/lce_regif.sv
module lce_regif
  import lce_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NCH-1:0]    ev,
  output logic              wr_evt,
  output logic [NCH-1:0]    wbits,
  output logic [NCH-1:0]    en,
  output logic [NCH-1:0]    masked,
  output logic [DATA_W-1:0] reg_rdata
);

  logic hit_raw, hit_msk, hit_en;
  logic [DATA_W-1:0] rd_mux;

  assign hit_raw = (reg_addr == ADDR_W'(OFS_RAW));
  assign hit_msk = (reg_addr == ADDR_W'(OFS_MSK));
  assign hit_en  = (reg_addr == ADDR_W'(OFS_EN));

  assign wr_evt = reg_wr && (hit_raw || hit_msk);
  assign wbits  = reg_wdata[NCH-1:0];
  assign masked = ev & en;

  always_ff @(posedge clk) begin
    if (rst)                  en <= '0;
    else if (reg_wr && hit_en) en <= reg_wdata[NCH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_raw)      rd_mux[NCH-1:0] = ev;
    else if (hit_msk) rd_mux[NCH-1:0] = masked;
    else if (hit_en)  rd_mux[NCH-1:0] = en;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:NCH] == '0); // R1
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && hit_en) |=> $stable(en)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R11

endmodule

// File: rtl/link_evt_irq.sv
module link_evt_irq
  import lce_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned NPHY   = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = sel_width(NPHY)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPHY-1:0]      link_stat,
  input  logic [NCH*SEL_W-1:0] phy_sel,
  input  logic                 test_en,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_o
);

  logic [NCH-1:0] hw_chg;
  logic [NCH-1:0] ev;
  logic [NCH-1:0] en;
  logic [NCH-1:0] masked;
  logic [NCH-1:0] wbits;
  logic           wr_evt;

  lce_change_det #(.NCH(NCH), .NPHY(NPHY), .SEL_W(SEL_W)) u_det (
    .clk(clk), .rst(rst), .link_stat(link_stat), .phy_sel(phy_sel), .chg(hw_chg)
  );

  lce_event_reg #(.NCH(NCH)) u_evt (
    .clk(clk), .rst(rst), .hw_chg(hw_chg), .wr_evt(wr_evt), .wbits(wbits),
    .test_en(test_en), .ev(ev)
  );

  lce_regif #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ev(ev), .wr_evt(wr_evt), .wbits(wbits), .en(en),
    .masked(masked), .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |masked;
  end

  AST_IRQ_UP: assert property (@(posedge clk) disable iff (rst)
    (|(ev & en)) |=> irq_o); // R10
  AST_IRQ_DN: assert property (@(posedge clk) disable iff (rst)
    !(|(ev & en)) |=> !irq_o); // R10

endmodule

// File: tb/test_link_evt_irq.sv
module test_link_evt_irq;

  localparam int unsigned NCH = 2;
  localparam int unsigned NPHY = 4;
  localparam int unsigned SELW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPHY-1:0] link_stat = '1;
  logic [NCH*SELW-1:0] phy_sel = '0;
  logic test_en = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  link_evt_irq #(.NCH(NCH), .NPHY(NPHY), .ADDR_W(4), .DATA_W(32)) i_link_evt_irq (
    .clk(clk), .rst(rst), .link_stat(link_stat), .phy_sel(phy_sel), .test_en(test_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0] expv;
    // links up during reset: the first sample must not raise events
    tick(3);
    rst = 1'b0;
    chk("R8 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R8 rdata after reset", reg_rdata, 32'd0);
    tick(3);
    rd(4'd0, d); chk("R12 raw quiet after reset", d, 32'd0);
    rd(4'd2, d); chk("R8 enable after reset", d, 32'd0);
    rd(4'd3, d); chk("R11 unmapped offset 3", d, 32'd0);
    rd(4'd9, d); chk("R11 unmapped offset 9", d, 32'd0);

    // R1 reserved bits on the enable word
    wr(4'd2, 32'hFFFF_FFFE);
    rd(4'd2, d); chk("R1 R11 enable write", d, 32'd2);
    wr(4'd2, 32'd0);

    // R2 R3 sweep of every select pair and every PHY, both edges
    link_stat = '0;
    for (int s0 = 0; s0 < NPHY; s0++) begin
      for (int s1 = 0; s1 < NPHY; s1++) begin
        phy_sel = {SELW'(s1), SELW'(s0)};
        tick(2);
        wr(4'd0, 32'd3);
        for (int p = 0; p < NPHY; p++) begin
          expv = {1'(s1 == p), 1'(s0 == p)};
          link_stat[p] = 1'b1;
          tick(1);
          rd(4'd0, d); chk("R2 R3 rising edge", d, {30'd0, expv});
          wr(4'd0, 32'd3);
          link_stat[p] = 1'b0;
          tick(1);
          rd(4'd0, d); chk("R2 R3 falling edge", d, {30'd0, expv});
          wr(4'd0, 32'd3);
        end
      end
    end

    // R9 change and clear in the same cycle
    phy_sel = {2'd1, 2'd0};
    tick(2);
    wr(4'd0, 32'd3);
    link_stat[0] = 1'b1;
    wr(4'd0, 32'd1);
    rd(4'd0, d); chk("R9 set wins over raw clear", d, 32'd1);
    link_stat[1] = 1'b1;
    wr(4'd1, 32'd2);
    rd(4'd0, d); chk("R9 set wins over masked clear", d, 32'd3);
    wr(4'd0, 32'd3);
    rd(4'd0, d); chk("R4 clear both", d, 32'd0);

    // R4 R5 R6 R7 R10 exhaustive write arithmetic
    for (int off = 0; off < 2; off++) begin
      for (int tm = 0; tm < 2; tm++) begin
        for (int init = 0; init < 4; init++) begin
          for (int dv = 0; dv < 4; dv++) begin
            logic [1:0] env;
            env = 2'((init + dv + off) % 4);
            test_en = 1'b0;
            wr(4'd0, 32'd3);
            test_en = 1'b1;
            wr(4'd0, 32'(init));
            wr(4'd2, 32'(env));
            test_en = 1'(tm);
            wr(4'(off), 32'hFFFF_FFFC | 32'(dv));
            test_en = 1'b0;
            expv = (tm == 1) ? (2'(init) | 2'(dv)) : (2'(init) & ~2'(dv));
            rd(4'd0, d);
            chk(tm == 1 ? "R5 test set" : (off == 0 ? "R4 raw clear" : "R7 masked clear"),
                d, {30'd0, expv});
            rd(4'd1, d); chk("R6 masked view", d, {30'd0, expv & env});
            chk("R10 irq", {31'd0, irq_o}, {31'd0, |(expv & env)});
          end
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule